// File: doc/BRIEF.md
# One-Time-Programmable Byte Array Core

This block is a synthesizable behavioural stand-in for a byte-wide memory whose bits can be cleared by programming but set again only by a bulk erase. Such memories are usually UV-erasable or one-time-programmable parts. Storage is an on-chip array. Pin levels are reduced to digital flags: an elevated program supply, an elevated level on address bit 9, and a chip-enable and output-enable pair. A registered decoder turns these flags into one of six modes each clock: read, output disable, standby, program, program inhibit and identifier read.

The output bus models a tri-state pad as a data byte plus a valid flag. When the flag is low the byte is held at zero. A bulk erase request sweeps every location back to all ones, one word per clock. The same sweep runs after reset, so the array always starts blank. The full address is 20 bits. The array keeps only the low `DEPTH_W` bits, so a smaller array aliases across the upper address space.

Top module: `otp_byte_array`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2^DEPTH_W clock cycles and `dout_vld` stays low. After that every location reads 0xFF.
- R2: If `ce_n`=0, `oe_n`=0, `supply_hv`=0 and `a9_hv`=0 are sampled on a clock edge while the block is idle, then after that edge `dout_vld`=1 and `dout` carries the byte stored at index `addr[DEPTH_W-1:0]`. Upper address bits are ignored.
- R3: `ce_n`=0 with `oe_n`=1 and `supply_hv`=0 (output disable) gives `dout_vld`=0 after the sampling edge.
- R4: `ce_n`=1 with `supply_hv`=0 (standby) gives `dout_vld`=0 after the sampling edge, whatever the value of `oe_n`.
- R5: With `supply_hv`=1, each low pulse on `ce_n` performs exactly one write. The write uses the address and data sampled in the first cycle of the pulse, and the stored byte becomes the old byte AND that data. Later data in the same pulse has no effect.
- R6: With `supply_hv`=1 and `ce_n`=1 (program inhibit), nothing is written, for any address or data.
- R7: Whenever `supply_hv`=1 is sampled, `dout_vld` is 0 after that edge.
- R8: In identifier mode (read controls active and `a9_hv`=1), an all-zero address returns 0x20 and address 0x00001 returns 0x42, with `dout_vld`=1.
- R9: In identifier mode, an address with any bit above bit 0 set returns 0xFF.
- R10: A sampled `erase_req` while idle raises `busy` on the next edge for exactly 2^DEPTH_W cycles, then every location reads 0xFF. An `erase_req` sampled while busy is ignored and does not lengthen the sweep.
- R11: While `busy` is high, `dout_vld` is 0 and a program pulse that starts during the sweep writes nothing.
- R12: Whenever `dout_vld` is 0, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the blanking sweep |
| addr | input | ADDR_W (20) | Byte address; the low DEPTH_W bits index the array |
| ce_n | input | 1 | Chip enable, active low; a low pulse with supply_hv writes |
| oe_n | input | 1 | Output enable, active low; ignored while supply_hv is high |
| supply_hv | input | 1 | Program supply at its elevated level |
| a9_hv | input | 1 | Address bit 9 held at its elevated level (identifier request) |
| din | input | DATA_W (8) | Byte to program |
| erase_req | input | 1 | Request a bulk erase to all ones |
| dout | output | DATA_W (8) | Read or identifier byte; 0x00 when not valid |
| dout_vld | output | 1 | dout is driven (low models high impedance) |
| busy | output | 1 | Erase sweep in progress |

## Verification
The bench keeps ADDR_W at 20 but builds the array with DEPTH_W=4, so it holds 16 bytes. Both the reset sweep and the erase sweep then last 16 cycles, short enough to count edge by edge. With so few locations the bench can read every one of them back. The small depth also makes aliasing visible: a write at index 5 reads back through an address whose upper bits are non-zero. Because the full 20-bit width is kept, the identifier checks can set bits far above the array index, such as bit 19, and confirm that they force the 0xFF response.

// File: rtl/otp_pkg.sv
// Shared types and constants for the one-time-programmable byte array.
// Assumes an 8-bit identifier byte; wider data paths zero-extend the codes.
package otp_pkg;

    // Operating modes decoded from the control flags
    typedef enum logic [2:0] {
        OM_STANDBY = 3'd0,
        OM_OFF     = 3'd1,
        OM_READ    = 3'd2,
        OM_IDENT   = 3'd3,
        OM_PROG    = 3'd4,
        OM_INHIBIT = 3'd5
    } otp_mode_e;

    localparam logic [7:0] ID_MAKER_BYTE = 8'h20;
    localparam logic [7:0] ID_PART_BYTE  = 8'h42;

    // Map the control flags to a mode; the program supply dominates output enable
    function automatic otp_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                              input logic supply_hv, input logic a9_hv);
        otp_mode_e m;
        if (supply_hv) begin
            m = ce_n ? OM_INHIBIT : OM_PROG;
        end else if (ce_n) begin
            m = OM_STANDBY;
        end else if (oe_n) begin
            m = OM_OFF;
        end else begin
            m = a9_hv ? OM_IDENT : OM_READ;
        end
        return m;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
// Registered mode decoder.
// Samples the control flags, address and data once per clock and flags the
// first cycle of each program pulse. Assumes inputs are synchronous to clk.
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              supply_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output otp_mode_e         mode_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              pulse_start_q
);

    otp_mode_e mode_d;

    // Combinational mode selection from the raw flags
    always_comb begin
        mode_d = decode_mode(ce_n, oe_n, supply_hv, a9_hv);
    end

    // Capture mode, address, data and the program-pulse leading edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= OM_STANDBY;
            addr_q        <= '0;
            din_q         <= '0;
            pulse_start_q <= 1'b0;
        end else begin
            mode_q        <= mode_d;
            addr_q        <= addr;
            din_q         <= din;
            pulse_start_q <= (mode_d == OM_PROG) && (mode_q != OM_PROG);
        end
    end

endmodule

// File: rtl/otp_array.sv
// Storage array with bit-clearing writes and a bulk erase sweep.
// A sweep sets one word to all ones per clock and blocks programming while
// busy. Reset starts the sweep, so the contents are defined without a reset
// on the storage itself. Reads are asynchronous on the registered index.
module otp_array #(
    parameter int DEPTH_W = 10,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_start,
    input  logic               erase_req,
    output logic               busy,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DATA_W-1:0]  mem [DEPTH];
    logic [DEPTH_W-1:0] sweep_q;
    logic               busy_q;

    // Sweep sequencer: runs from reset or an idle erase request to the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b1;
            sweep_q <= '0;
        end else if (busy_q) begin
            if (&sweep_q) begin
                busy_q <= 1'b0;
            end
            sweep_q <= sweep_q + DEPTH_W'(1);
        end else if (erase_req) begin
            busy_q  <= 1'b1;
            sweep_q <= '0;
        end
    end

    // Storage update: the sweep sets ones, a program pulse can only clear bits
    always_ff @(posedge clk) begin
        if (busy_q) begin
            mem[sweep_q] <= '1;
        end else if (wr_start) begin
            mem[idx] <= mem[idx] & wdata;
        end
    end

    // Read path from the registered index
    always_comb begin
        rd_data = mem[idx];
    end

    assign busy = busy_q;

endmodule

// File: rtl/otp_out_stage.sv
// Output selection.
// Drives the array byte in read mode or a fixed identifier byte in
// identifier mode; otherwise the byte is zero and the valid flag is low.
module otp_out_stage
    import otp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  otp_mode_e         mode_q,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic [DATA_W-1:0] ident_byte;

    // Identifier byte: two defined codes, everything else blank
    always_comb begin
        if (addr_q[ADDR_W-1:1] != '0) begin
            ident_byte = '1;
        end else if (addr_q[0]) begin
            ident_byte = DATA_W'(ID_PART_BYTE);
        end else begin
            ident_byte = DATA_W'(ID_MAKER_BYTE);
        end
    end

    // Output mux with float-to-zero when not driving
    always_comb begin
        dout     = '0;
        dout_vld = 1'b0;
        if (!busy) begin
            case (mode_q)
                OM_READ: begin
                    dout     = rd_data;
                    dout_vld = 1'b1;
                end
                OM_IDENT: begin
                    dout     = ident_byte;
                    dout_vld = 1'b1;
                end
                default: begin
                    dout     = '0;
                    dout_vld = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/otp_byte_array.sv
// Top of the one-time-programmable byte array core.
// Chains the registered decoder, the storage array and the output stage.
// Assumes DEPTH_W <= ADDR_W; the array uses the low DEPTH_W address bits.
module otp_byte_array
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DEPTH_W = 10,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              supply_hv,
    input  logic              a9_hv,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_req,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              busy
);

    otp_mode_e         mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              pulse_start_q;
    logic [DATA_W-1:0] rd_data;

    otp_mode_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .supply_hv     (supply_hv),
        .a9_hv         (a9_hv),
        .addr          (addr),
        .din           (din),
        .mode_q        (mode_q),
        .addr_q        (addr_q),
        .din_q         (din_q),
        .pulse_start_q (pulse_start_q)
    );

    otp_array #(
        .DEPTH_W (DEPTH_W),
        .DATA_W  (DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (addr_q[DEPTH_W-1:0]),
        .wdata     (din_q),
        .wr_start  (pulse_start_q),
        .erase_req (erase_req),
        .busy      (busy),
        .rd_data   (rd_data)
    );

    otp_out_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_out (
        .mode_q   (mode_q),
        .busy     (busy),
        .addr_q   (addr_q),
        .rd_data  (rd_data),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

endmodule

// File: rtl/otp_byte_array_chk.sv
// Protocol checker for otp_byte_array, attached with bind.
// Relates the control flags sampled at one edge to the outputs after it,
// and measures the sweep length with a local counter.
module otp_byte_array_chk #(
    parameter int ADDR_W  = 20,
    parameter int DEPTH_W = 10,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              supply_hv,
    input logic              a9_hv,
    input logic              erase_req,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic              busy
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DEPTH_W:0] run_q;

    // Count consecutive busy cycles for the sweep-length check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + (DEPTH_W+1)'(1);
        end else begin
            run_q <= '0;
        end
    end

    a_r12_float_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> dout == '0);

    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !supply_hv) |=> !dout_vld);

    a_r3_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !supply_hv) |=> !dout_vld);

    a_r7_supply_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        supply_hv |=> !dout_vld);

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !supply_hv && !busy && !erase_req) |=> dout_vld);

    a_r8_ident_maker: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !supply_hv && a9_hv && addr == '0 && !busy && !erase_req)
        |=> dout == DATA_W'(8'h20));

    a_r8_ident_part: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !supply_hv && a9_hv && addr == ADDR_W'(1) && !busy && !erase_req)
        |=> dout == DATA_W'(8'h42));

    a_r9_ident_other: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !supply_hv && a9_hv && addr[ADDR_W-1:1] != '0 && !busy && !erase_req)
        |=> dout == '1);

    a_r11_busy_blank: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_vld);

    a_r10_erase_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_req) |=> busy);

    a_r10_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == (DEPTH_W+1)'(DEPTH));

endmodule

bind otp_byte_array otp_byte_array_chk #(
    .ADDR_W  (ADDR_W),
    .DEPTH_W (DEPTH_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .supply_hv (supply_hv),
    .a9_hv     (a9_hv),
    .erase_req (erase_req),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .busy      (busy)
);

// File: tb/otp_byte_array_bench.sv
// Scoreboard bench: driver tasks queue expected output bytes with the cycle
// they become due; a monitor compares them at the falling edge.
module otp_byte_array_bench;

    localparam int AW    = 20;
    localparam int DEPW  = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << DEPW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          supply_hv = 1'b0;
    logic          a9_hv = 1'b0;
    logic [DW-1:0] din = '0;
    logic          erase_req = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_vld;
    logic          busy;

    always #5 clk = ~clk;

    otp_byte_array #(.ADDR_W(AW), .DEPTH_W(DEPW), .DATA_W(DW)) u_otp_byte_array (
        .clk (clk), .rst_n (rst_n), .addr (addr), .ce_n (ce_n), .oe_n (oe_n),
        .supply_hv (supply_hv), .a9_hv (a9_hv), .din (din), .erase_req (erase_req),
        .dout (dout), .dout_vld (dout_vld), .busy (busy)
    );

    int cyc = 0;
    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;
    int   due_q[$];
    logic [8:0] exp_q[$];
    string tag_q[$];
    logic [DW-1:0] model [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare every queued item whose cycle has arrived
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            logic [8:0] e;
            string t;
            void'(due_q.pop_front());
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({dout_vld, dout} == e, t, {dout_vld, dout}, e);
        end
    end

    // Driver: apply one cycle of inputs, optionally queue the expected output
    task automatic drive(input logic c, input logic o, input logic s, input logic h,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit chk, input logic [8:0] e, input string tag);
        ce_n = c; oe_n = o; supply_hv = s; a9_hv = h; addr = a; din = d;
        if (chk) begin
            due_q.push_back(cyc + 1);
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b1, {1'b1, model[a[DEPW-1:0]]}, tag);
    endtask

    task automatic id_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        drive(1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b1, {1'b1, e}, tag);
    endtask

    // Program pulse of len cycles; only the first cycle's data may land
    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len,
                        input logic [DW-1:0] later);
        drive(1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b1, 9'h000, "R7 quiet during program");
        for (int i = 1; i < len; i++)
            drive(1'b0, 1'b0, 1'b1, 1'b0, a, later, 1'b1, 9'h000, "R7 quiet, oe_n low");
        drive(1'b1, 1'b1, 1'b1, 1'b0, a, later, 1'b1, 9'h000, "R6 inhibit quiet");
        model[a[DEPW-1:0]] = model[a[DEPW-1:0]] & d;
    endtask

    // Bulk erase with a repeated request, a program pulse and a read while busy
    task automatic erase_run();
        int n;
        erase_req = 1'b1; ce_n = 1'b1; oe_n = 1'b1; supply_hv = 1'b0; a9_hv = 1'b0;
        @(negedge clk);
        erase_req = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            n++;
            if (n == 2) erase_req = 1'b1;
            if (n == 3) erase_req = 1'b0;
            if (n == 4) begin ce_n = 1'b0; supply_hv = 1'b1; addr = 20'h00003; din = 8'h00; end
            if (n == 5) begin ce_n = 1'b1; supply_hv = 1'b0; end
            if (n == 6) begin ce_n = 1'b0; oe_n = 1'b0; addr = 20'h00003; end
            if (n == 7) begin
                check(dout_vld == 1'b0, "R11 read blanked while busy", {8'h00, dout_vld}, 9'h000);
                ce_n = 1'b1; oe_n = 1'b1;
            end
            @(negedge clk);
        end
        check(n == DEPTH, "R10 erase sweep length", 9'(n), 9'(DEPTH));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && dout_vld == 1'b0 && dout == 8'h00, "R1 reset state",
              {dout_vld, dout}, 9'h000);
        rst_n = 1'b1;
        n = 0;
        while (busy && n < 100) begin
            if (dout_vld) check(1'b0, "R11 valid during reset sweep", 9'h001, 9'h000);
            n++;
            @(negedge clk);
        end
        check(n == DEPTH, "R1 reset sweep length", 9'(n), 9'(DEPTH));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R1 blank after reset");

        prog(20'h00003, 8'hA5, 1, 8'h00);
        rd(20'h00003, "R5 first program");
        prog(20'h00003, 8'h3C, 1, 8'h00);
        rd(20'h00003, "R5 AND with stored byte");
        prog(20'h00005, 8'h00, 1, 8'h00);
        rd(20'hABCD5, "R2 upper address bits ignored");
        rd(20'h00004, "R2 neighbour untouched");
        prog(20'h00007, 8'hF0, 3, 8'h0F);
        rd(20'h00007, "R5 one write per pulse");
        prog(20'h00008, 8'h7E, 1, 8'h00);
        rd(20'h00008, "R2 programmed byte read back");

        drive(1'b1, 1'b1, 1'b1, 1'b0, 20'h00009, 8'h00, 1'b1, 9'h000, "R6 inhibit cycle 1");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 20'h00009, 8'h00, 1'b1, 9'h000, "R6 inhibit cycle 2");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 20'h00009, 8'h11, 1'b1, 9'h000, "R6 inhibit cycle 3");
        rd(20'h00009, "R6 inhibit leaves byte");

        drive(1'b0, 1'b1, 1'b0, 1'b0, 20'h00003, 8'h00, 1'b1, 9'h000, "R3 output disable");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 20'h00000, 8'h00, 1'b1, 9'h000, "R3 disable with a9");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h00003, 8'h00, 1'b1, 9'h000, "R4 standby oe_n low");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 20'h00003, 8'h00, 1'b1, 9'h000, "R4 standby oe_n high");
        rd(20'h00003, "R2 read after standby");

        id_rd(20'h00000, 8'h20, "R8 maker code");
        id_rd(20'h00001, 8'h42, "R8 part code");
        id_rd(20'h00002, 8'hFF, "R9 bit 1 set");
        id_rd(20'h80001, 8'hFF, "R9 bit 19 set");
        id_rd(20'h00010, 8'hFF, "R9 bit 4 set");
        rd(20'h00000, "R2 ident leaves array");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 8'h00, 1'b1, 9'h000, "R12 idle zero");

        erase_run();
        rd(20'h00003, "R11 program during sweep ignored");
        rd(20'h00007, "R10 erased byte");
        rd(20'h00008, "R10 erased byte 2");
        rd(20'h00005, "R10 erased byte 3");
        prog(20'h0000F, 8'h5A, 1, 8'h00);
        rd(20'h0000F, "R5 program after erase");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 8'h00, 1'b0, 9'h000, "");
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule